// File: doc/BRIEF.md
# DMA Channel Slot Scheduler

This block decides which DMA channel, and in which direction, may move data next. The decision comes from a table that software writes. Each 8-bit table entry names one channel and marks the slot as receive or transmit. While the block is enabled, a slot pointer walks the table from entry 0 up to a programmed last index, one entry per clock, and then wraps back to 0.

At each slot the block looks at the request line of the named channel in the named direction. If that request is high, the block issues a single-cycle grant on the next clock, carrying the channel number and a direction bit. If the request is low, the slot is skipped. Because a channel can appear in the table any number of times and in any order, software shapes bandwidth and latency per channel and direction simply by rewriting the table.

Software programs the block through a simple register port. The usual sequence is to clear the enable bit, rewrite the table, then set the enable bit again. Table writes made while the block is enabled are still honoured: they are picked up the next time the pointer reaches the changed entry.

Top module: `dma_slot_sched`

## Requirements
- R1: After a synchronous reset, the block is in this state: the enable bit is 0, the last index is 0, every table entry is 0x00, `gnt_valid` is low, `gnt_chan` and `gnt_rx` are 0, and `reg_rdata` is 0.
- R2: Register map and read-back.
  - The control word is at byte offset 0x000. Bit 31 is the enable bit, bits [IDX_W-1:0] hold the last index, and all other bits read as 0.
  - Table word w is at byte offset 0x800 + 4·w, for w < DEPTH/4. Entry 4·w + k sits in bits [8k+7:8k] of that word.
  - `reg_rdata` shows the addressed word one cycle after `reg_rd`.
  - An unmapped address, or one with bits [1:0] not equal to 0, reads as 0. A write to such an address changes nothing.
- R3: Bit 7 of an entry selects the direction: 1 means receive, 0 means transmit. Bits [6:0] hold the channel number. A grant carries exactly that channel in `gnt_chan` and that direction in `gnt_rx`.
- R4: While the block is enabled, the pointer serves one entry per cycle, whether or not that entry is granted. It runs 0, 1, …, last, then returns to 0. If the pointer is already at or above the last index, its next step is 0.
- R5: `gnt_valid` is high in the cycle after a slot exactly when the request for that slot's channel and direction was high in the slot's cycle. A request in the other direction does not satisfy the slot. When `gnt_valid` is low, `gnt_chan` and `gnt_rx` are 0.
- R6: While the block is disabled, it issues no grant and the pointer rests at entry 0. After the enable bit is set, entry 0 is the first slot served, whatever the pointer was when the block was disabled.
- R7: An entry whose channel field is NUM_CH or greater never produces a grant. Its slot is still consumed.
- R8: A table write made while the block is enabled takes effect from the next visit to the changed entry. A visit in the same cycle as the write still uses the old entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte address of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| tx_req | input | NUM_CH | Transmit request, one bit per channel |
| rx_req | input | NUM_CH | Receive request, one bit per channel |
| gnt_valid | output | 1 | Single-cycle grant pulse |
| gnt_chan | output | CH_W | Granted channel number |
| gnt_rx | output | 1 | Granted direction: 1 receive, 0 transmit |

## Verification
The checker covers the following properties on every cycle:
- no grant one cycle after a disabled cycle;
- the pointer resting at 0 while the block is disabled;
- each pointer step, either +1 or a wrap to 0 at the last index;
- every grant being backed by a request of the matching direction one cycle earlier;
- every granted channel lying in range.

Some behaviours show only in the bench's scenarios, which compare against a behavioural model on every clock:
- the exact field packing and read-back of the register map;
- the order in which table entries are served;
- entry 0 being the first slot served after re-enabling;
- silent skipping of out-of-range channels;
- the point at which a table write made while the block runs takes effect.

// File: rtl/dma_sched_pkg.sv
package dma_sched_pkg;

    localparam int ENTRY_W          = 8;
    localparam int LANES_PER_WORD   = 4;
    localparam int CHAN_FIELD_W     = 7;
    localparam int TABLE_BASE_BYTE  = 'h800;
    localparam int CTRL_EN_BIT      = 31;

    typedef struct packed {
        logic                    is_rx;
        logic [CHAN_FIELD_W-1:0] chan;
    } slot_entry_t;

    function automatic logic [31:0] pack_ctrl(input logic en, input logic [15:0] last_idx);
        logic [31:0] w;
        w = 32'(last_idx);
        w[CTRL_EN_BIT] = en;
        return w;
    endfunction

endpackage

// File: rtl/sched_cfg_regs.sv
module sched_cfg_regs
    import dma_sched_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int ADDR_W = 12
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr,
    input  logic                     rd,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [31:0]              wdata,
    output logic [31:0]              rdata,
    output logic                     en,
    output logic [$clog2(DEPTH)-1:0] last_idx,
    input  logic [$clog2(DEPTH)-1:0] slot_idx,
    output slot_entry_t              slot
);
    localparam int IDX_W  = $clog2(DEPTH);
    localparam int WORDS  = DEPTH / LANES_PER_WORD;
    localparam int WIDX_W = IDX_W - 2;
    localparam int WA_W   = ADDR_W - 2;
    localparam logic [WA_W-1:0] BASE_W = WA_W'(TABLE_BASE_BYTE / 4);

    logic [WA_W-1:0]   word_addr;
    logic [WA_W-1:0]   tbl_off;
    logic              aligned;
    logic              ctrl_hit;
    logic              tbl_hit;
    logic [WIDX_W-1:0] tbl_word;
    logic [31:0]       word_arr [WORDS];
    logic [31:0]       slot_word;

    assign word_addr = addr[ADDR_W-1:2];
    assign aligned   = (addr[1:0] == 2'b00);
    assign ctrl_hit  = aligned && (word_addr == '0);
    assign tbl_off   = word_addr - BASE_W;
    assign tbl_hit   = aligned && (word_addr >= BASE_W) && (tbl_off < WA_W'(WORDS));
    assign tbl_word  = tbl_off[WIDX_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            en       <= 1'b0;
            last_idx <= '0;
        end else if (wr && ctrl_hit) begin
            en       <= wdata[CTRL_EN_BIT];
            last_idx <= wdata[IDX_W-1:0];
        end
    end

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        logic [31:0] word_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                word_q <= '0;
            end else if (wr && tbl_hit && (tbl_word == WIDX_W'(w))) begin
                word_q <= wdata;
            end
        end
        assign word_arr[w] = word_q;
    end

    assign slot_word = word_arr[slot_idx[IDX_W-1:2]];
    assign slot      = slot_entry_t'(slot_word[{slot_idx[1:0], 3'b000} +: ENTRY_W]);

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (rd) begin
            if (ctrl_hit) begin
                rdata <= pack_ctrl(en, 16'(last_idx));
            end else if (tbl_hit) begin
                rdata <= word_arr[tbl_word];
            end else begin
                rdata <= '0;
            end
        end
    end

endmodule

// File: rtl/sched_slot_walker.sv
module sched_slot_walker #(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [IDX_W-1:0] last_idx,
    output logic [IDX_W-1:0] ptr
);
    logic at_end;

    assign at_end = (ptr >= last_idx);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            ptr <= '0;
        end else if (at_end) begin
            ptr <= '0;
        end else begin
            ptr <= ptr + 1'b1;
        end
    end

endmodule

// File: rtl/sched_grant_pick.sv
module sched_grant_pick
    import dma_sched_pkg::*;
#(
    parameter int NUM_CH = 30,
    parameter int CH_W   = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  slot_entry_t       slot,
    input  logic [NUM_CH-1:0] tx_req,
    input  logic [NUM_CH-1:0] rx_req,
    output logic              gnt_valid,
    output logic [CH_W-1:0]   gnt_chan,
    output logic              gnt_rx
);
    logic pending;
    logic hit;

    always_comb begin
        pending = 1'b0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (slot.chan == CHAN_FIELD_W'(i)) begin
                pending = slot.is_rx ? rx_req[i] : tx_req[i];
            end
        end
    end

    assign hit = en && pending;

    always_ff @(posedge clk) begin
        if (rst) begin
            gnt_valid <= 1'b0;
            gnt_chan  <= '0;
            gnt_rx    <= 1'b0;
        end else begin
            gnt_valid <= hit;
            gnt_chan  <= hit ? slot.chan[CH_W-1:0] : '0;
            gnt_rx    <= hit ? slot.is_rx : 1'b0;
        end
    end

endmodule

// File: rtl/dma_slot_sched.sv
module dma_slot_sched
    import dma_sched_pkg::*;
#(
    parameter int NUM_CH = 30,
    parameter int DEPTH  = 64,
    parameter int ADDR_W = 12,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [NUM_CH-1:0] tx_req,
    input  logic [NUM_CH-1:0] rx_req,
    output logic              gnt_valid,
    output logic [CH_W-1:0]   gnt_chan,
    output logic              gnt_rx
);
    localparam int IDX_W = $clog2(DEPTH);

    logic             cfg_en;
    logic [IDX_W-1:0] cfg_last;
    logic [IDX_W-1:0] slot_ptr;
    slot_entry_t      cur_slot;

    sched_cfg_regs #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr       (reg_wr),
        .rd       (reg_rd),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .en       (cfg_en),
        .last_idx (cfg_last),
        .slot_idx (slot_ptr),
        .slot     (cur_slot)
    );

    sched_slot_walker #(.IDX_W(IDX_W)) u_walk (
        .clk      (clk),
        .rst      (rst),
        .en       (cfg_en),
        .last_idx (cfg_last),
        .ptr      (slot_ptr)
    );

    sched_grant_pick #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_pick (
        .clk       (clk),
        .rst       (rst),
        .en        (cfg_en),
        .slot      (cur_slot),
        .tx_req    (tx_req),
        .rx_req    (rx_req),
        .gnt_valid (gnt_valid),
        .gnt_chan  (gnt_chan),
        .gnt_rx    (gnt_rx)
    );

endmodule

// File: rtl/dma_sched_checker.sv
module dma_sched_checker #(
    parameter int NUM_CH = 30,
    parameter int IDX_W  = 6,
    parameter int CH_W   = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              en,
    input logic [IDX_W-1:0]  last_idx,
    input logic [IDX_W-1:0]  ptr,
    input logic [NUM_CH-1:0] tx_req,
    input logic [NUM_CH-1:0] rx_req,
    input logic              gnt_valid,
    input logic [CH_W-1:0]   gnt_chan,
    input logic              gnt_rx
);
    logic [NUM_CH-1:0] tx_prev;
    logic [NUM_CH-1:0] rx_prev;

    always_ff @(posedge clk) begin
        tx_prev <= tx_req;
        rx_prev <= rx_req;
    end

    a_r6_no_grant_when_off: assert property (@(posedge clk) disable iff (rst)
        !en |=> !gnt_valid);

    a_r6_ptr_rests_at_zero: assert property (@(posedge clk) disable iff (rst)
        !en |=> (ptr == '0));

    a_r4_ptr_wraps: assert property (@(posedge clk) disable iff (rst)
        (en && (ptr >= last_idx)) |=> (ptr == '0));

    a_r4_ptr_steps: assert property (@(posedge clk) disable iff (rst)
        (en && (ptr < last_idx)) |=> (ptr == IDX_W'($past(ptr) + 1'b1)));

    a_r5_rx_grant_backed: assert property (@(posedge clk) disable iff (rst)
        (gnt_valid && gnt_rx) |-> rx_prev[gnt_chan]);

    a_r5_tx_grant_backed: assert property (@(posedge clk) disable iff (rst)
        (gnt_valid && !gnt_rx) |-> tx_prev[gnt_chan]);

    a_r7_chan_in_range: assert property (@(posedge clk) disable iff (rst)
        gnt_valid |-> (32'(gnt_chan) < NUM_CH));

endmodule

bind dma_slot_sched dma_sched_checker #(.NUM_CH(NUM_CH), .IDX_W(IDX_W), .CH_W(CH_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .en        (cfg_en),
    .last_idx  (cfg_last),
    .ptr       (slot_ptr),
    .tx_req    (tx_req),
    .rx_req    (rx_req),
    .gnt_valid (gnt_valid),
    .gnt_chan  (gnt_chan),
    .gnt_rx    (gnt_rx)
);

// File: tb/tb_dma_slot_sched.sv
`timescale 1ns/1ps
module tb_dma_slot_sched;
    localparam int NUM_CH = 30;
    localparam int DEPTH  = 64;
    localparam int ADDR_W = 12;
    localparam int CH_W   = 5;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              reg_wr = 1'b0;
    logic              reg_rd = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic [NUM_CH-1:0] tx_req = '0;
    logic [NUM_CH-1:0] rx_req = '0;
    logic              gnt_valid;
    logic [CH_W-1:0]   gnt_chan;
    logic              gnt_rx;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    dma_slot_sched #(.NUM_CH(NUM_CH), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_req(tx_req), .rx_req(rx_req),
        .gnt_valid(gnt_valid), .gnt_chan(gnt_chan), .gnt_rx(gnt_rx)
    );

    // Behavioural reference model
    int          m_tbl [DEPTH];
    int          m_en, m_last, m_ptr;
    int          m_gv, m_gc, m_gr;
    logic [31:0] m_rd;

    function automatic logic [31:0] model_read(input logic [ADDR_W-1:0] a);
        int w;
        logic [31:0] v;
        v = '0;
        w = int'(a) >> 2;
        if (a[1:0] == 2'b00) begin
            if (w == 0) begin
                v = 32'(m_last);
                v[31] = (m_en != 0);
            end else if (w >= 'h200 && w < 'h200 + DEPTH/4) begin
                for (int k = 0; k < 4; k++) v[8*k +: 8] = 8'(m_tbl[4*(w-'h200)+k]);
            end
        end
        return v;
    endfunction

    always @(posedge clk) begin : model
        int ent, ch, rx, w;
        logic pend;
        if (rst) begin
            m_en = 0; m_last = 0; m_ptr = 0; m_gv = 0; m_gc = 0; m_gr = 0; m_rd = '0;
            for (int i = 0; i < DEPTH; i++) m_tbl[i] = 0;
        end else begin
            if (reg_rd) m_rd = model_read(reg_addr);
            ent = m_tbl[m_ptr];
            ch  = ent & 127;
            rx  = (ent >> 7) & 1;
            pend = 1'b0;
            if (ch < NUM_CH) pend = (rx != 0) ? rx_req[ch] : tx_req[ch];
            if (m_en != 0 && pend) begin
                m_gv = 1; m_gc = ch; m_gr = rx;
            end else begin
                m_gv = 0; m_gc = 0; m_gr = 0;
            end
            if (m_en == 0 || m_ptr >= m_last) m_ptr = 0;
            else m_ptr = m_ptr + 1;
            if (reg_wr && reg_addr[1:0] == 2'b00) begin
                w = int'(reg_addr) >> 2;
                if (w == 0) begin
                    m_en = int'(reg_wdata[31]);
                    m_last = int'(reg_wdata[5:0]);
                end else if (w >= 'h200 && w < 'h200 + DEPTH/4) begin
                    for (int k = 0; k < 4; k++) m_tbl[4*(w-'h200)+k] = int'(reg_wdata[8*k +: 8]);
                end
            end
        end
    end

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            n_chk++;
            if (int'(gnt_valid) != m_gv || int'(gnt_chan) != m_gc || int'(gnt_rx) != m_gr) begin
                n_fail++;
                $display("FAIL R5 grant: act v=%0d ch=%0d rx=%0d exp v=%0d ch=%0d rx=%0d",
                         gnt_valid, gnt_chan, gnt_rx, m_gv, m_gc, m_gr);
            end
            n_chk++;
            if (reg_rdata !== m_rd) begin
                n_fail++;
                $display("FAIL R2 rdata: act %08h exp %08h", reg_rdata, m_rd);
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: act %0d exp %0d", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = ADDR_W'(a); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input int a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = ADDR_W'(a);
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    function automatic logic [31:0] ent4(input int e0, input int e1, input int e2, input int e3);
        return {8'(e3), 8'(e2), 8'(e1), 8'(e0)};
    endfunction

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog: act timeout exp finish");
        summary();
    end

    initial begin : stim
        logic [31:0] d;
        logic [31:0] lfsr;
        int cnt, cnt_rx, cnt9, cnt3;
        int exp_ch [4];
        lfsr = 32'h1ACE_B00C;
        exp_ch = '{1, 2, 3, 4};
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        chk(gnt_valid == 1'b0, "R1 grant after reset", int'(gnt_valid), 0);
        rd_reg('h000, d); chk(d == 32'h0, "R1 ctrl after reset", int'(d), 0);
        rd_reg('h800, d); chk(d == 32'h0, "R1 table after reset", int'(d), 0);

        // Full 60-entry table: entry e -> channel e>>1, rx = e&1
        for (int w = 0; w < 15; w++) begin
            wr_reg('h800 + 4*w, ent4(((4*w) >> 1), ((4*w+1) >> 1) | 128,
                                     ((4*w+2) >> 1), ((4*w+3) >> 1) | 128));
        end
        tx_req = '1; rx_req = '0;
        wr_reg('h000, 32'h8000_003B);
        // R2: read-back
        rd_reg('h000, d); chk(d == 32'h8000_003B, "R2 ctrl readback", int'(d), 32'h8000_003B);
        rd_reg('h80C, d); chk(d == 32'h8707_8606, "R2 table word readback", int'(d), 32'h8707_8606);
        rd_reg('h802, d); chk(d == 32'h0, "R2 misaligned read", int'(d), 0);
        wr_reg('h404, 32'hFFFF_FFFF);
        rd_reg('h404, d); chk(d == 32'h0, "R2 unmapped read", int'(d), 0);
        rd_reg('h000, d); chk(d == 32'h8000_003B, "R2 unmapped write ignored", int'(d), 32'h8000_003B);

        // R5: only transmit requests -> only transmit slots granted
        cnt = 0; cnt_rx = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (gnt_valid) begin cnt++; if (gnt_rx) cnt_rx++; end
        end
        chk(cnt == 30, "R5 tx-only grant count", cnt, 30);
        chk(cnt_rx == 0, "R3 no receive grant without rx request", cnt_rx, 0);

        // Pseudo-random requests, model compared each cycle
        for (int i = 0; i < 500; i++) begin
            @(negedge clk);
            lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
            tx_req = NUM_CH'(lfsr);
            rx_req = NUM_CH'(lfsr >> 2);
        end

        // R4: short table with wrap at last index 3
        wr_reg('h000, 32'h0);
        wr_reg('h800, ent4(1, 2 | 128, 3, 4 | 128));
        tx_req = '1; rx_req = '1;
        wr_reg('h000, 32'h8000_0003);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            chk(gnt_valid && int'(gnt_chan) == exp_ch[i % 4], "R4 slot order",
                int'(gnt_chan), exp_ch[i % 4]);
            chk(int'(gnt_rx) == (i % 2), "R3 direction bit", int'(gnt_rx), i % 2);
        end

        // R6: disable mid-run, then re-enable
        repeat (2) @(negedge clk);
        wr_reg('h000, 32'h0000_0003);
        @(negedge clk);
        cnt = 0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (gnt_valid) cnt++;
        end
        chk(cnt == 0, "R6 no grant while disabled", cnt, 0);
        wr_reg('h000, 32'h8000_0003);
        @(negedge clk);
        chk(gnt_valid && gnt_chan == 5'd1 && !gnt_rx, "R6 entry 0 first after enable", int'(gnt_chan), 1);

        // R8: rewrite entry 2 while running
        wr_reg('h800, ent4(1, 2 | 128, 9, 4 | 128));
        cnt9 = 0; cnt3 = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (gnt_valid && gnt_chan == 5'd9) cnt9++;
            if (gnt_valid && gnt_chan == 5'd3) cnt3++;
        end
        chk(cnt9 == 2, "R8 new entry served", cnt9, 2);
        chk(cnt3 == 0, "R8 old entry gone", cnt3, 0);

        // R7: out-of-range channel fields never grant
        wr_reg('h800, ent4(30, 127 | 128, 31, 5));
        @(negedge clk);
        cnt = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (gnt_valid) begin
                cnt++;
                chk(gnt_chan == 5'd5, "R7 only in-range channel", int'(gnt_chan), 5);
            end
        end
        chk(cnt == 2, "R7 grant count", cnt, 2);

        repeat (4) @(negedge clk);
        summary();
    end

endmodule